// File: doc/BRIEF.md
# Ternary Scale-Factor Accumulation Engine

This block applies trained scale factors to the very low-precision outputs of a compute array without a multiplier. Each array column delivers a binary or ternary result, so scaling that result by its column's scale factor reduces to one of three actions: add the scale factor to a running accumulator, subtract it, or do nothing. The engine holds two small synchronous memories. One stores fixed-point scale factors, indexed by column. The other stores partial-sum accumulators, indexed by accumulator row.

Work arrives as a valid/ready stream of (scale-factor row, accumulator row, code) tuples. Each nonzero tuple passes through a three-stage pipeline. The first stage reads both memories. The second stage runs a chain of one-bit add/subtract cells, one cell per bit. The third stage writes the result back to the accumulator row. A new tuple can be accepted every cycle. When a tuple reads a row that an older tuple is still updating, the fresh result is forwarded to it. A zero code causes no memory activity at all, so a sparse input stream saves energy.

Scale factors are loaded through a separate write port. A clear command zeroes every accumulator. A read command returns one accumulator once all earlier work has been written back.

Top module: `tsf_accum_engine`

## Requirements
- R1: In ternary mode (`mode_binary`=0), code 2'b01 adds scale factor row `in_sf_row` to accumulator row `in_acc_row`, and code 2'b11 subtracts it. Accumulators are 16-bit two's complement and wrap modulo 2^16.
- R2: In ternary mode, codes 2'b00 and 2'b10 mean zero. Such a tuple is accepted, changes no accumulator, leaves `last_cb` unchanged, and does not raise `busy`.
- R3: In binary mode (`mode_binary`=1), code bit 0 set to 1 adds and bit 0 set to 0 subtracts. Bit 1 is ignored, and no tuple is ever skipped.
- R4: With `in_ready` high, one tuple is accepted per cycle. Back-to-back tuples that target the same accumulator row give the same result as if they were applied one at a time.
- R5: From the second clock edge after a nonzero tuple is accepted, `last_cb` holds the final output of the chain for that tuple: the carry for an add and the borrow (unsigned a < b) for a subtract.
- R6: A scale factor written through the write port in one cycle is used by every tuple accepted in a later cycle.
- R7: A pulse on `clr` waits for the pipeline to drain and then zeroes all accumulator rows, one row per cycle. `in_ready` is low from the cycle after the pulse until the clear completes.
- R8: A pulse on `rd_req` captures `rd_addr`. `in_ready` is low from the next cycle until the read is served. `rd_valid` then pulses for one cycle, and `rd_data` carries the row value that includes every tuple accepted up to and including the request cycle.
- R9: After reset, `in_ready` is 1 and `busy`, `rd_valid` and `last_cb` are 0. Accumulator contents are undefined until the first clear. `busy` is high while any tuple, clear or read is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_binary | input | 1 | 1 = binary code interpretation, 0 = ternary |
| sf_we | input | 1 | Scale-factor write enable |
| sf_waddr | input | 5 | Scale-factor row to write |
| sf_wdata | input | 16 | Signed scale factor |
| in_valid | input | 1 | Tuple valid |
| in_ready | output | 1 | Engine can accept a tuple |
| in_sf_row | input | 5 | Column index, which selects the scale-factor row |
| in_acc_row | input | 5 | Accumulator row to update |
| in_code | input | 2 | Ternary or binary code |
| clr | input | 1 | Clear-all command pulse |
| rd_req | input | 1 | Accumulator read request pulse |
| rd_addr | input | 5 | Accumulator row to read |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Accumulator value read |
| last_cb | output | 1 | Carry/borrow of the most recent nonzero operation |
| busy | output | 1 | Work is still in progress |

## Verification
Most internal faults in this engine show up only when an accumulator is read back. A forwarding error affects only tuples that hit the same row within two cycles of each other. It corrupts that row silently, and the damage becomes visible at the next `rd_data` for the row, which arrives a few cycles after the pipeline drains. A decode or chain fault appears as a wrong sum or a wrong `last_cb` two edges after acceptance. A zero code that slips through appears at once as a spurious `busy` pulse.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } op_e;

  // Map an incoming code to an action; binary mode never skips.
  function automatic op_e decode_code(input logic binary, input logic [1:0] code);
    if (binary) begin
      return code[0] ? OP_ADD : OP_SUB;
    end
    case (code)
      2'b01:   return OP_ADD;
      2'b11:   return OP_SUB;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tsf_regfile.sv
module tsf_regfile #(
  parameter int W = 16,
  parameter int D = 32,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [D];

  // Read-first synchronous RAM, suitable for block RAM inference.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tsf_addsub_chain.sv
module tsf_addsub_chain #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cb_out
);

  logic [W:0]   c;
  logic [W-1:0] bx;

  assign c[0] = sub;

  for (genvar k = 0; k < W; k++) begin : g_cell
    assign bx[k]    = b[k] ^ sub;
    assign sum[k]   = a[k] ^ bx[k] ^ c[k];
    assign c[k+1]   = (a[k] & bx[k]) | (c[k] & (a[k] ^ bx[k]));
  end

  // Carry for add, borrow for subtract.
  assign cb_out = c[W] ^ sub;

  // R1 / R5: the bit chain agrees with a whole-word reference.
  logic [W:0] ref_w;
  always_comb begin
    ref_w = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, sub};
    a_r1_chain_matches: assert ({c[W], sum} == ref_w);
  end

endmodule

// File: rtl/tsf_accum_engine.sv
module tsf_accum_engine #(
  parameter int SF_W     = 16,
  parameter int ACC_W    = 16,
  parameter int SF_ROWS  = 32,
  parameter int ACC_ROWS = 32,
  localparam int SF_AW   = $clog2(SF_ROWS),
  localparam int ACC_AW  = $clog2(ACC_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_binary,
  input  logic              sf_we,
  input  logic [SF_AW-1:0]  sf_waddr,
  input  logic [SF_W-1:0]   sf_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SF_AW-1:0]  in_sf_row,
  input  logic [ACC_AW-1:0] in_acc_row,
  input  logic [1:0]        in_code,
  input  logic              clr,
  input  logic              rd_req,
  input  logic [ACC_AW-1:0] rd_addr,
  output logic              rd_valid,
  output logic [ACC_W-1:0]  rd_data,
  output logic              last_cb,
  output logic              busy
);
  import tsf_pkg::*;

  localparam logic [ACC_AW-1:0] LAST_ROW = ACC_AW'(ACC_ROWS - 1);

  // ---------------- control state ----------------
  logic              clr_pend, clearing;
  logic [ACC_AW-1:0] clr_cnt;
  logic              rd_pend, rd_issue_d;
  logic [ACC_AW-1:0] rd_addr_q;

  // ---------------- pipeline state ----------------
  logic              s1_v, s1_sub;
  logic [ACC_AW-1:0] s1_row;
  logic              s2_v;
  logic [ACC_AW-1:0] s2_row;
  logic [ACC_W-1:0]  s2_res;
  logic              wb_v;
  logic [ACC_AW-1:0] wb_row;
  logic [ACC_W-1:0]  wb_res;

  logic              drained, start_clear, rd_issue, in_fire;
  op_e               dec_op;

  assign drained     = !s1_v && !s2_v;
  assign start_clear = clr_pend && drained && !clearing;
  assign rd_issue    = rd_pend && drained && !clr_pend && !clearing;
  assign in_ready    = !rd_pend && !clr_pend && !clearing;
  assign in_fire     = in_valid && in_ready;
  assign dec_op      = decode_code(mode_binary, in_code);
  assign busy        = s1_v || s2_v || clr_pend || clearing || rd_pend || rd_issue_d;

  // ---------------- memories (read stage) ----------------
  logic [SF_W-1:0]   sf_q;
  logic [ACC_W-1:0]  acc_q;
  logic              acc_we;
  logic [ACC_AW-1:0] acc_waddr, acc_raddr;
  logic [ACC_W-1:0]  acc_wdata;

  assign acc_raddr = rd_issue ? rd_addr_q : in_acc_row;
  assign acc_we    = clearing || s2_v;
  assign acc_waddr = clearing ? clr_cnt : s2_row;
  assign acc_wdata = clearing ? '0 : s2_res;

  tsf_regfile #(.W(SF_W), .D(SF_ROWS)) u_sf_mem (
    .clk   (clk),
    .we    (sf_we),
    .waddr (sf_waddr),
    .wdata (sf_wdata),
    .raddr (in_sf_row),
    .rdata (sf_q)
  );

  tsf_regfile #(.W(ACC_W), .D(ACC_ROWS)) u_acc_mem (
    .clk   (clk),
    .we    (acc_we),
    .waddr (acc_waddr),
    .wdata (acc_wdata),
    .raddr (acc_raddr),
    .rdata (acc_q)
  );

  // ---------------- compute stage ----------------
  logic [ACC_W-1:0] sf_ext, acc_fwd, sum_c;
  logic             cb_c;

  if (SF_W == ACC_W) begin : g_sf_same
    assign sf_ext = sf_q;
  end else begin : g_sf_ext
    assign sf_ext = {{(ACC_W-SF_W){sf_q[SF_W-1]}}, sf_q};
  end

  // Newest in-flight write to the same row wins.
  always_comb begin
    if (s2_v && s2_row == s1_row)      acc_fwd = s2_res;
    else if (wb_v && wb_row == s1_row) acc_fwd = wb_res;
    else                               acc_fwd = acc_q;
  end

  tsf_addsub_chain #(.W(ACC_W)) u_chain (
    .a      (acc_fwd),
    .b      (sf_ext),
    .sub    (s1_sub),
    .sum    (sum_c),
    .cb_out (cb_c)
  );

  // ---------------- sequential ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v       <= 1'b0;
      s1_sub     <= 1'b0;
      s1_row     <= '0;
      s2_v       <= 1'b0;
      s2_row     <= '0;
      s2_res     <= '0;
      wb_v       <= 1'b0;
      wb_row     <= '0;
      wb_res     <= '0;
      last_cb    <= 1'b0;
      clr_pend   <= 1'b0;
      clearing   <= 1'b0;
      clr_cnt    <= '0;
      rd_pend    <= 1'b0;
      rd_addr_q  <= '0;
      rd_issue_d <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      // read stage
      s1_v   <= in_fire && (dec_op != OP_NONE);
      s1_row <= in_acc_row;
      s1_sub <= (dec_op == OP_SUB);
      // compute stage
      s2_v   <= s1_v;
      s2_row <= s1_row;
      s2_res <= sum_c;
      if (s1_v) last_cb <= cb_c;
      // store stage shadow, for forwarding past the RAM's read-first edge
      wb_v   <= s2_v;
      wb_row <= s2_row;
      wb_res <= s2_res;

      // clear sequencing
      if (clr)              clr_pend <= 1'b1;
      else if (start_clear) clr_pend <= 1'b0;
      if (start_clear) begin
        clearing <= 1'b1;
        clr_cnt  <= '0;
      end else if (clearing) begin
        if (clr_cnt == LAST_ROW) clearing <= 1'b0;
        clr_cnt <= clr_cnt + 1'b1;
      end

      // read sequencing
      if (rd_req && !rd_pend) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= rd_addr;
      end else if (rd_issue) begin
        rd_pend <= 1'b0;
      end
      rd_issue_d <= rd_issue;
      rd_valid   <= rd_issue_d;
      if (rd_issue_d) rd_data <= acc_q;
    end
  end

  // ---------------- assertions ----------------
  a_r2_zero_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_fire && !mode_binary && !in_code[0]) |=> ##1 !s2_v);

  a_r4_single_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clearing, s2_v}));

  a_r5_cb_holds: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> $stable(last_cb));

  a_r7_clear_on_empty: assert property (@(posedge clk) disable iff (rst)
    clearing |-> (!s1_v && !s2_v));

  a_r8_read_after_drain: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !s2_v);

  a_r9_idle_ready: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready);

endmodule

// File: tb/sim_tsf_accum_engine.sv
module sim_tsf_accum_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_binary = 1'b0;
  logic        sf_we = 1'b0;
  logic [4:0]  sf_waddr = '0;
  logic [15:0] sf_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_sf_row = '0;
  logic [4:0]  in_acc_row = '0;
  logic [1:0]  in_code = '0;
  logic        clr = 1'b0;
  logic        rd_req = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        last_cb;
  logic        busy;

  always #5 clk = ~clk;

  tsf_accum_engine u0 (
    .clk(clk), .rst(rst), .mode_binary(mode_binary),
    .sf_we(sf_we), .sf_waddr(sf_waddr), .sf_wdata(sf_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_sf_row(in_sf_row),
    .in_acc_row(in_acc_row), .in_code(in_code),
    .clr(clr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .last_cb(last_cb), .busy(busy)
  );

  int tests = 0;
  int fails = 0;
  logic [15:0] m_sf  [32];
  logic [15:0] m_acc [32];
  logic        m_cb = 1'b0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model of one accepted tuple.
  function automatic void model_op(input logic [4:0] j, input logic [4:0] i,
                                   input logic [1:0] code, input logic bin);
    logic [16:0] t;
    bit add, sub;
    add = bin ? code[0]  : (code == 2'b01);
    sub = bin ? !code[0] : (code == 2'b11);
    if (add) begin
      t = {1'b0, m_acc[i]} + {1'b0, m_sf[j]};
      m_cb = t[16];
      m_acc[i] = t[15:0];
    end else if (sub) begin
      m_cb = (m_acc[i] < m_sf[j]);
      m_acc[i] = m_acc[i] - m_sf[j];
    end
  endfunction

  task automatic wsf(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    sf_we = 1'b1; sf_waddr = a; sf_wdata = d;
    @(posedge clk); #1;
    sf_we = 1'b0;
    m_sf[a] = d;
  endtask

  task automatic op(input logic [4:0] j, input logic [4:0] i, input logic [1:0] code);
    @(negedge clk);
    in_valid = 1'b1; in_sf_row = j; in_acc_row = i; in_code = code;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    model_op(j, i, code, mode_binary);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    int n;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_req = 1'b0;
    n = 0;
    @(negedge clk);
    while (!rd_valid && n < 100) begin @(negedge clk); n++; end
    chk(rd_valid && rd_data == m_acc[a], tag, int'(rd_data), int'(m_acc[a]));
  endtask

  task automatic do_clear();
    int n;
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R7 in_ready low during clear", int'(in_ready), 0);
    n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    chk(!busy && in_ready, "R7 clear completes", int'(busy), 0);
    for (int k = 0; k < 32; k++) m_acc[k] = '0;
  endtask

  task automatic chk_cb(input string tag);
    @(negedge clk);
    @(negedge clk);
    chk(last_cb == m_cb, tag, int'(last_cb), int'(m_cb));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R9 reset rd_valid", int'(rd_valid), 0);
    chk(last_cb == 1'b0, "R9 reset last_cb", int'(last_cb), 0);

    for (int k = 0; k < 32; k++) wsf(5'(k), 16'($urandom));
    do_clear();
    rd(5'd0, "R7 row0 cleared");
    rd(5'd31, "R7 row31 cleared");

    // R1 add, subtract and sign
    wsf(5'd3, 16'h1234);
    op(5'd3, 5'd7, 2'b01);
    rd(5'd7, "R1 add");
    op(5'd3, 5'd7, 2'b11);
    op(5'd3, 5'd7, 2'b11);
    rd(5'd7, "R1 subtract to negative");

    // R5 carry/borrow, R1 wrap
    wsf(5'd4, 16'h0001);
    op(5'd4, 5'd9, 2'b11);
    chk_cb("R5 borrow on 0-1");
    op(5'd4, 5'd9, 2'b01);
    chk_cb("R5 carry on wrap");
    rd(5'd9, "R1 wrap to zero");
    op(5'd4, 5'd9, 2'b01);
    chk_cb("R5 no carry");

    // R2 zero codes
    op(5'd4, 5'd9, 2'b00);
    @(negedge clk);
    chk(!busy, "R2 zero code busy", int'(busy), 0);
    op(5'd4, 5'd9, 2'b10);
    @(negedge clk);
    chk(!busy, "R2 code 10 busy", int'(busy), 0);
    chk(last_cb == m_cb, "R2 last_cb kept", int'(last_cb), int'(m_cb));
    rd(5'd9, "R2 row unchanged");

    // R4 back-to-back same row
    for (int k = 0; k < 8; k++) op(5'(k), 5'd12, (k % 3 == 2) ? 2'b11 : 2'b01);
    rd(5'd12, "R4 back-to-back same row");
    op(5'd1, 5'd13, 2'b01);
    op(5'd2, 5'd14, 2'b01);
    op(5'd3, 5'd13, 2'b11);
    rd(5'd13, "R4 gap of one");

    // R3 binary mode
    mode_binary = 1'b1;
    op(5'd5, 5'd15, 2'b00);
    op(5'd6, 5'd15, 2'b10);
    op(5'd7, 5'd15, 2'b01);
    op(5'd8, 5'd15, 2'b11);
    mode_binary = 1'b0;
    rd(5'd15, "R3 binary codes");

    // R6 scale factor update then immediate use
    wsf(5'd20, 16'h7FFF);
    op(5'd20, 5'd21, 2'b01);
    wsf(5'd20, 16'h8000);
    op(5'd20, 5'd21, 2'b01);
    rd(5'd21, "R6 fresh scale factor");

    // R8 in_ready drops after read request
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 5'd21;
    @(posedge clk); #1;
    rd_req = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R8 in_ready low after rd_req", int'(in_ready), 0);
    repeat (6) @(negedge clk);

    // Random mix of codes and rows, with periodic reads
    for (int n = 0; n < 600; n++) begin
      op(5'($urandom), 5'($urandom % 8), 2'($urandom));
      if (n % 75 == 74) rd(5'($urandom % 8), "R4 random row");
    end
    for (int k = 0; k < 8; k++) rd(5'(k), "R1 random final");

    // Clear again after random traffic
    do_clear();
    rd(5'd3, "R7 second clear");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule